// File: doc/BRIEF.md
# Dual-Half Address Register Bank with Offset Update

This block holds the pointer state of a 16-bit address generator. It is split into two identical halves. The low half serves pointer indices 0 to 3 and the high half serves indices 4 to 7. Each half keeps four address registers, four offset registers and four modifier registers. Each half also has one offset adder, which moves a chosen address register by +1, -1, +N or -N. N is always the offset register with the same index as the address register being moved.

Every register can be written and read over a 24-bit data bus. The 16-bit value sits in the low two bytes of that bus. On a write the upper byte is thrown away, and on a read the upper byte is returned as zero.

Each half takes one update request per cycle. It always shows the current, pre-update value of the selected address register on its own address output, so the caller can use it as a post-modify pointer. There is no back-pressure: an update whose valid is high is taken at the next rising clock edge, with no ready pin. Both halves may update in the same cycle. Only linear arithmetic is built. A modifier value other than all ones is still treated as linear, and it raises the unsupported flag of that half.

Top module: `agu_regbank_top`

## Requirements
- R1: A 3-bit register index selects the half by bit 2 (0 = low, 1 = high). The lower bits pick one of the four registers in that half. A half's update index addresses only its own four registers.
- R2: The read class selects the register file: 0 = address, 1 = offset, 2 = modifier, 3 = none, which reads as zero. The read data is combinational and equals {8'h00, value}.
- R3: A bus write with class 0, 1 or 2 stores wr_data[15:0] into the indexed register at the clock edge. Bits 23:16 are discarded.
- R4: While rst_n is low, every address and offset register becomes 16'h0000 and every modifier register becomes 16'hFFFF.
- R5: With upd_valid high, op 2'b00 adds 1 to the selected address register and op 2'b01 subtracts 1. The new value is registered at the clock edge.
- R6: Op 2'b10 adds the offset register of the same index, and op 2'b11 subtracts it. The offset value used is the one held before that edge.
- R7: The arithmetic wraps modulo 2^16: 16'hFFFF + 1 gives 16'h0000, and 16'h0000 - 1 gives 16'hFFFF.
- R8: Each half's address output combinationally shows the current value of the address register named by its update index, whether or not valid is high.
- R9: Both halves can update in the same cycle, each independently of the other.
- R10: When a bus write to an address register and an update of that same register fall in the same cycle, the bus value is stored.
- R11: A half's unsupported flag is high exactly when its valid is high and the selected modifier register is not 16'hFFFF. The update is still done linearly.
- R12: A bus write with class 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_wr_cls | input | 2 | Write register class |
| bus_wr_idx | input | 3 | Write register index |
| bus_wr_data | input | 24 | Write data from the bus |
| bus_rd_cls | input | 2 | Read register class |
| bus_rd_idx | input | 3 | Read register index |
| bus_rd_data | output | 24 | Zero-extended read data |
| lo_upd_valid | input | 1 | Low half update request |
| lo_upd_idx | input | 2 | Low half register select |
| lo_upd_op | input | 2 | Low half update operation |
| lo_addr | output | 16 | Low half pre-update address |
| lo_unsup | output | 1 | Low half non-linear modifier flag |
| hi_upd_valid | input | 1 | High half update request |
| hi_upd_idx | input | 2 | High half register select |
| hi_upd_op | input | 2 | High half update operation |
| hi_addr | output | 16 | High half pre-update address |
| hi_unsup | output | 1 | High half non-linear modifier flag |

## Verification
The update path is tried with all four operations on small values, on values next to the 16-bit wrap, and on offsets loaded with their top bit set. These cases tell a correct two's-complement subtract apart from a plain add, and they show whether the carry is dropped. Random traffic mixes bus writes, reads and updates in both halves at once. That separates the two halves from each other, and it separates the three register files from each other. Directed cycles place a bus write and an update on the same register, which shows which one takes priority. They also write garbage into the upper byte and write with the idle class, to show that both are discarded. Modifier writes that alternate between all ones and other values check that the unsupported flag follows the modifier of the selected index only.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    OP_INC  = 2'b00,
    OP_DEC  = 2'b01,
    OP_ADDN = 2'b10,
    OP_SUBN = 2'b11
  } upd_op_e;

  typedef enum logic [1:0] {
    CLS_ADDR = 2'b00,
    CLS_OFFS = 2'b01,
    CLS_MODF = 2'b10,
    CLS_NONE = 2'b11
  } reg_cls_e;
endpackage

// File: rtl/agu_offset_adder.sv
module agu_offset_adder #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offs,
  input  logic [1:0]    op,
  output logic [AW-1:0] result
);
  import agu_pkg::*;

  logic [AW-1:0] operand;

  // Pick one operand, then use a single adder. The carry out is dropped.
  always_comb begin
    unique case (upd_op_e'(op))
      OP_INC:  operand = AW'(1);
      OP_DEC:  operand = '1;
      OP_ADDN: operand = offs;
      default: operand = (~offs) + AW'(1);
    endcase
  end

  assign result = base + operand;
endmodule

// File: rtl/agu_half.sv
module agu_half #(
  parameter int AW   = 16,
  parameter int NREG = 4,
  localparam int LIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_cls,
  input  logic [LIW-1:0] wr_idx,
  input  logic [AW-1:0]  wr_val,
  input  logic [1:0]     rd_cls,
  input  logic [LIW-1:0] rd_idx,
  output logic [AW-1:0]  rd_val,
  input  logic           upd_valid,
  input  logic [LIW-1:0] upd_idx,
  input  logic [1:0]     upd_op,
  output logic [AW-1:0]  addr,
  output logic           unsup
);
  import agu_pkg::*;

  logic [AW-1:0] ptr_q  [NREG];
  logic [AW-1:0] step_q [NREG];
  logic [AW-1:0] mod_q  [NREG];
  logic [AW-1:0] next_ptr;

  assign addr  = ptr_q[upd_idx];
  assign unsup = upd_valid && (mod_q[upd_idx] != '1);

  agu_offset_adder #(.AW(AW)) i_adder (
    .base   (ptr_q[upd_idx]),
    .offs   (step_q[upd_idx]),
    .op     (upd_op),
    .result (next_ptr)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == LIW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[g]  <= '0;
        step_q[g] <= '0;
        mod_q[g]  <= '1;
      end else begin
        // A bus write to this pointer overrides an update of it.
        if (hit_wr && reg_cls_e'(wr_cls) == CLS_ADDR)
          ptr_q[g] <= wr_val;
        else if (upd_valid && upd_idx == LIW'(g))
          ptr_q[g] <= next_ptr;
        if (hit_wr && reg_cls_e'(wr_cls) == CLS_OFFS)
          step_q[g] <= wr_val;
        if (hit_wr && reg_cls_e'(wr_cls) == CLS_MODF)
          mod_q[g] <= wr_val;
      end
    end
  end

  always_comb begin
    unique case (reg_cls_e'(rd_cls))
      CLS_ADDR: rd_val = ptr_q[rd_idx];
      CLS_OFFS: rd_val = step_q[rd_idx];
      CLS_MODF: rd_val = mod_q[rd_idx];
      default:  rd_val = '0;
    endcase
  end
endmodule

// File: rtl/agu_regbank_top.sv
module agu_regbank_top #(
  parameter int AW        = 16,
  parameter int BW        = 24,
  parameter int HALF_REGS = 4,
  localparam int LIW      = $clog2(HALF_REGS),
  localparam int GIW      = LIW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr_en,
  input  logic [1:0]     bus_wr_cls,
  input  logic [GIW-1:0] bus_wr_idx,
  input  logic [BW-1:0]  bus_wr_data,
  input  logic [1:0]     bus_rd_cls,
  input  logic [GIW-1:0] bus_rd_idx,
  output logic [BW-1:0]  bus_rd_data,
  input  logic           lo_upd_valid,
  input  logic [LIW-1:0] lo_upd_idx,
  input  logic [1:0]     lo_upd_op,
  output logic [AW-1:0]  lo_addr,
  output logic           lo_unsup,
  input  logic           hi_upd_valid,
  input  logic [LIW-1:0] hi_upd_idx,
  input  logic [1:0]     hi_upd_op,
  output logic [AW-1:0]  hi_addr,
  output logic           hi_unsup
);
  localparam int NHALF = 2;

  logic           h_valid [NHALF];
  logic [LIW-1:0] h_idx   [NHALF];
  logic [1:0]     h_op    [NHALF];
  logic [AW-1:0]  h_addr  [NHALF];
  logic           h_unsup [NHALF];
  logic [AW-1:0]  h_rd    [NHALF];

  assign h_valid[0] = lo_upd_valid;
  assign h_idx[0]   = lo_upd_idx;
  assign h_op[0]    = lo_upd_op;
  assign h_valid[1] = hi_upd_valid;
  assign h_idx[1]   = hi_upd_idx;
  assign h_op[1]    = hi_upd_op;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic sel_wr;
    assign sel_wr = bus_wr_en && (bus_wr_idx[LIW] == 1'(h));

    agu_half #(.AW(AW), .NREG(HALF_REGS)) i_half (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (sel_wr),
      .wr_cls    (bus_wr_cls),
      .wr_idx    (bus_wr_idx[LIW-1:0]),
      .wr_val    (bus_wr_data[AW-1:0]),
      .rd_cls    (bus_rd_cls),
      .rd_idx    (bus_rd_idx[LIW-1:0]),
      .rd_val    (h_rd[h]),
      .upd_valid (h_valid[h]),
      .upd_idx   (h_idx[h]),
      .upd_op    (h_op[h]),
      .addr      (h_addr[h]),
      .unsup     (h_unsup[h])
    );
  end

  assign lo_addr  = h_addr[0];
  assign lo_unsup = h_unsup[0];
  assign hi_addr  = h_addr[1];
  assign hi_unsup = h_unsup[1];

  assign bus_rd_data = {{(BW-AW){1'b0}}, h_rd[bus_rd_idx[LIW]]};
endmodule

// File: rtl/agu_regbank_chk.sv
module agu_regbank_chk #(
  parameter int AW        = 16,
  parameter int BW        = 24,
  parameter int HALF_REGS = 4,
  localparam int LIW      = $clog2(HALF_REGS),
  localparam int GIW      = LIW + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr_en,
  input logic [1:0]     bus_wr_cls,
  input logic [GIW-1:0] bus_wr_idx,
  input logic [BW-1:0]  bus_wr_data,
  input logic [1:0]     bus_rd_cls,
  input logic [GIW-1:0] bus_rd_idx,
  input logic [BW-1:0]  bus_rd_data,
  input logic           lo_upd_valid,
  input logic [LIW-1:0] lo_upd_idx,
  input logic [1:0]     lo_upd_op,
  input logic [AW-1:0]  lo_addr,
  input logic           lo_unsup,
  input logic           hi_upd_valid,
  input logic [LIW-1:0] hi_upd_idx,
  input logic [1:0]     hi_upd_op,
  input logic [AW-1:0]  hi_addr,
  input logic           hi_unsup
);
  logic lo_hit, hi_hit;
  assign lo_hit = bus_wr_en && bus_wr_cls == 2'b00 && bus_wr_idx == {1'b0, lo_upd_idx};
  assign hi_hit = bus_wr_en && bus_wr_cls == 2'b00 && bus_wr_idx == {1'b1, hi_upd_idx};

  // R2
  rd_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_data[BW-1:AW] == '0);

  // R11
  unsup_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_unsup && !lo_upd_valid) && !(hi_unsup && !hi_upd_valid));

  // R5
  lo_inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_upd_valid && lo_upd_op == 2'b00 && !lo_hit) ##1 (lo_upd_idx == $past(lo_upd_idx))
    |-> lo_addr == AW'($past(lo_addr) + AW'(1)));

  // R5
  hi_dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_upd_valid && hi_upd_op == 2'b01 && !hi_hit) ##1 (hi_upd_idx == $past(hi_upd_idx))
    |-> hi_addr == AW'($past(hi_addr) - AW'(1)));

  // R10
  lo_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_upd_valid && lo_hit) ##1 (lo_upd_idx == $past(lo_upd_idx))
    |-> lo_addr == $past(bus_wr_data[AW-1:0]));
endmodule

bind agu_regbank_top agu_regbank_chk #(.AW(AW), .BW(BW), .HALF_REGS(HALF_REGS)) i_chk (.*);

// File: tb/test_agu_regbank_top.sv
`timescale 1ns/1ps
module test_agu_regbank_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [1:0]  bus_wr_cls = '0;
  logic [2:0]  bus_wr_idx = '0;
  logic [23:0] bus_wr_data = '0;
  logic [1:0]  bus_rd_cls = '0;
  logic [2:0]  bus_rd_idx = '0;
  logic [23:0] bus_rd_data;
  logic        lo_upd_valid = 1'b0, hi_upd_valid = 1'b0;
  logic [1:0]  lo_upd_idx = '0, lo_upd_op = '0, hi_upd_idx = '0, hi_upd_op = '0;
  logic [15:0] lo_addr, hi_addr;
  logic        lo_unsup, hi_unsup;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] er [8];
  logic [15:0] en [8];
  logic [15:0] em [8];

  always #2.5 clk = ~clk;

  agu_regbank_top i_agu_regbank_top (.*);

  task automatic chk(string tag, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] upd(logic [15:0] b, logic [15:0] n, logic [1:0] op);
    case (op)
      2'b00: return b + 16'd1;
      2'b01: return b - 16'd1;
      2'b10: return b + n;
      default: return b - n;
    endcase
  endfunction

  function automatic logic [15:0] rd_model(logic [1:0] c, logic [2:0] i);
    case (c)
      2'b00: return er[i];
      2'b01: return en[i];
      2'b10: return em[i];
      default: return 16'h0000;
    endcase
  endfunction

  // Inputs are already set after a falling edge: check, advance the model, go to the next falling edge.
  task automatic step(string tag);
    logic [15:0] nr [8];
    int gl, gh;
    #1;
    gl = {1'b0, lo_upd_idx};
    gh = {1'b1, hi_upd_idx};
    chk(tag, "lo_addr", {8'h0, lo_addr}, {8'h0, er[gl]});
    chk(tag, "hi_addr", {8'h0, hi_addr}, {8'h0, er[gh]});
    chk(tag, "lo_unsup", {23'h0, lo_unsup}, {23'h0, lo_upd_valid && em[gl] != 16'hFFFF});
    chk(tag, "hi_unsup", {23'h0, hi_unsup}, {23'h0, hi_upd_valid && em[gh] != 16'hFFFF});
    chk(tag, "rd_data", bus_rd_data, {8'h0, rd_model(bus_rd_cls, bus_rd_idx)});
    nr = er;
    if (lo_upd_valid) nr[gl] = upd(er[gl], en[gl], lo_upd_op);
    if (hi_upd_valid) nr[gh] = upd(er[gh], en[gh], hi_upd_op);
    er = nr;
    if (bus_wr_en) begin
      case (bus_wr_cls)
        2'b00: er[bus_wr_idx] = bus_wr_data[15:0];
        2'b01: en[bus_wr_idx] = bus_wr_data[15:0];
        2'b10: em[bus_wr_idx] = bus_wr_data[15:0];
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr_en = 0; lo_upd_valid = 0; hi_upd_valid = 0;
  endtask

  task automatic wr(logic [1:0] c, logic [2:0] i, logic [23:0] d, string tag);
    idle();
    bus_wr_en = 1; bus_wr_cls = c; bus_wr_idx = i; bus_wr_data = d;
    step(tag);
    idle();
  endtask

  task automatic rd(logic [1:0] c, logic [2:0] i, string tag);
    idle();
    bus_rd_cls = c; bus_rd_idx = i;
    step(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 8; i++) begin er[i] = 0; en[i] = 0; em[i] = 16'hFFFF; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4: reset values of all three files
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 8; i++) rd(2'(c), 3'(i), "R4");
    // R3: the upper byte is discarded on a write
    wr(2'b01, 3'd5, 24'hABCDEF, "R3");
    rd(2'b01, 3'd5, "R3");
    // R12: a write with class 3 changes nothing
    wr(2'b11, 3'd0, 24'h001234, "R12");
    rd(2'b00, 3'd0, "R12"); rd(2'b01, 3'd0, "R12"); rd(2'b10, 3'd0, "R12");
    // R7: wrap on increment and on decrement
    wr(2'b00, 3'd0, 24'h00FFFF, "R7");
    lo_upd_valid = 1; lo_upd_idx = 0; lo_upd_op = 2'b00; step("R7");
    lo_upd_idx = 1; lo_upd_op = 2'b01; step("R7");
    idle(); lo_upd_idx = 0; step("R7");
    lo_upd_idx = 1; step("R7");
    // R6: +N and -N with an offset whose top bit is set
    wr(2'b01, 3'd2, 24'h008003, "R6");
    wr(2'b00, 3'd2, 24'h000010, "R6");
    lo_upd_valid = 1; lo_upd_idx = 2; lo_upd_op = 2'b10; step("R6");
    lo_upd_op = 2'b11; step("R6");
    lo_upd_op = 2'b11; step("R6");
    idle(); step("R6");
    // R1 and R9: index 6 is reached through the high half; both halves step together
    wr(2'b00, 3'd6, 24'h000100, "R1");
    wr(2'b01, 3'd6, 24'h000020, "R1");
    lo_upd_valid = 1; lo_upd_idx = 3; lo_upd_op = 2'b01;
    hi_upd_valid = 1; hi_upd_idx = 2; hi_upd_op = 2'b10; step("R9");
    idle(); step("R9");
    rd(2'b00, 3'd6, "R1"); rd(2'b00, 3'd2, "R1");
    // R10: a bus write beats an update of the same pointer
    lo_upd_valid = 1; lo_upd_idx = 1; lo_upd_op = 2'b00;
    bus_wr_en = 1; bus_wr_cls = 2'b00; bus_wr_idx = 3'd1; bus_wr_data = 24'h55AAAA;
    step("R10");
    idle(); step("R10");
    // R11: a non-linear modifier raises the flag but the update stays linear
    wr(2'b10, 3'd4, 24'h000007, "R11");
    hi_upd_valid = 1; hi_upd_idx = 0; hi_upd_op = 2'b00; step("R11");
    step("R11");
    hi_upd_idx = 1; step("R11");
    idle(); hi_upd_idx = 0; step("R11");
    // R8 with R2 and R5: random mixed traffic
    for (int k = 0; k < 3000; k++) begin
      bus_wr_en    = ($urandom % 4) == 0;
      bus_wr_cls   = 2'($urandom);
      bus_wr_idx   = 3'($urandom);
      bus_wr_data  = ($urandom % 3 == 0) ? 24'hFFFFFF : 24'($urandom);
      bus_rd_cls   = 2'($urandom);
      bus_rd_idx   = 3'($urandom);
      lo_upd_valid = 1'($urandom);
      lo_upd_idx   = 2'($urandom);
      lo_upd_op    = 2'($urandom);
      hi_upd_valid = 1'($urandom);
      hi_upd_idx   = 2'($urandom);
      hi_upd_op    = 2'($urandom);
      step("R8/R2/R5");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule